// File: doc/BRIEF.md
# Synchronous Memory Sleep Controller

This block sits between the command decoder and the core of a synchronous memory and controls its low-power sleep state. An active-high sleep request is sampled on the rising clock edge. Once it has stayed high for a fixed number of edges, the controller enters sleep. While asleep it blocks every command to the core and turns off the output drivers. The contents of the memory core are not touched, so stored data survives sleep.

When the request drops, the controller stays in a recovery window for a parameterised number of clock cycles. In that window read and deselect traffic reaches the core, but writes are suppressed. An attempted write during recovery sets a sticky error flag that only reset clears. If the request falls before sleep has been reached, the controller returns straight to normal operation with no recovery window.

A two-bit status output reports the current phase. Its encoding is: 0 normal, 1 entering, 2 asleep, 3 recovering.

Top module: `mem_sleep_ctrl`

## Requirements
- R1: A synchronous reset sets status to 0 (normal), clears the write error flag and turns on the output drivers (`drv_en_o` = 1).
- R2: The request is sampled only on rising clock edges. In normal state, a high request moves status to 1 at that edge. If the request stays high, status becomes 2 (asleep) at the ENTER_CYC-th edge, counting the first edge that sampled it high (default 2).
- R3: If the request is sampled low while status is 1, the next status is 0 and no recovery window follows.
- R4: While status is 2, `core_vld_o`, `core_wr_o` and `drv_en_o` are all 0 whatever the command inputs are, and commands presented there do not set the error flag.
- R5: A low request sampled while status is 2 moves status to 3. Status stays at 3 for exactly REC_CYC cycles (default 5) and then returns to 0.
- R6: While status is 3, `core_vld_o` equals `cmd_vld_i & ~cmd_wr_i`, `core_wr_o` is 0 and `drv_en_o` is 1.
- R7: A write (`cmd_vld_i` = 1 and `cmd_wr_i` = 1) presented while status is 3 sets `wr_err_o` at the next edge. The flag then stays set until reset.
- R8: While status is 0 or 1, `core_vld_o` equals `cmd_vld_i`, `core_wr_o` equals `cmd_vld_i & cmd_wr_i` and `drv_en_o` is 1.
- R9: A high request sampled while status is 3 moves status to 1 and restarts the entry count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| slp_req_i | input | 1 | Sleep request, active high |
| cmd_vld_i | input | 1 | Command valid from the decoder |
| cmd_wr_i | input | 1 | Command is a write |
| core_vld_o | output | 1 | Gated command valid to the core |
| core_wr_o | output | 1 | Gated write strobe to the core |
| drv_en_o | output | 1 | Output driver enable; 0 means high impedance |
| state_o | output | 2 | Phase: 0 normal, 1 entering, 2 asleep, 3 recovering |
| wr_err_o | output | 1 | Sticky flag: a write was attempted during recovery |

## Verification
The hardest condition to reach from the ports is a write that lands inside the short recovery window, and likewise a request that rises again before recovery has finished. Both need the request held high through entry and then dropped at the right moment. The random stimulus therefore changes the request only rarely, producing long high and low runs that pass through every phase. Directed sequences then place a write on each recovery cycle, abort entry after a single edge, and re-request sleep in the middle of recovery.

// File: rtl/mem_sleep_pkg.sv
package mem_sleep_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE   = 2'd0,
    PH_ENTERING = 2'd1,
    PH_SLEEP    = 2'd2,
    PH_RECOVER  = 2'd3
  } slp_phase_t;

  // Returns {write strobe, command valid} as seen by the core.
  function automatic logic [1:0] gate_cmd(slp_phase_t ph, logic vld, logic wr);
    logic [1:0] r;
    case (ph)
      PH_ACTIVE, PH_ENTERING: r = {vld & wr, vld};
      PH_RECOVER:             r = {1'b0, vld & ~wr};
      default:                r = 2'b00;
    endcase
    return r;
  endfunction

  function automatic logic drivers_on(slp_phase_t ph);
    return ph != PH_SLEEP;
  endfunction

  function automatic logic last_tick(int unsigned cnt, int unsigned len);
    return (cnt + 1) >= len;
  endfunction

endpackage

// File: rtl/slp_phase_fsm.sv
module slp_phase_fsm
  import mem_sleep_pkg::*;
#(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned REC_CYC   = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  output slp_phase_t phase,
  output logic       enter_evt,
  output logic       wake_evt
);
  localparam int unsigned MAXC = (ENTER_CYC > REC_CYC) ? ENTER_CYC : REC_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  slp_phase_t ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic enter_done, rec_done;

  assign enter_done = last_tick(32'(cnt_q), ENTER_CYC);
  assign rec_done   = last_tick(32'(cnt_q), REC_CYC);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_ACTIVE: if (req) begin
        cnt_d = '0;
        ph_d  = (ENTER_CYC <= 1) ? PH_SLEEP : PH_ENTERING;
        if (ENTER_CYC > 1) cnt_d = CW'(1);
      end
      PH_ENTERING: begin
        if (!req) begin
          ph_d  = PH_ACTIVE;
          cnt_d = '0;
        end else if (enter_done) begin
          ph_d  = PH_SLEEP;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      PH_SLEEP: if (!req) begin
        ph_d  = PH_RECOVER;
        cnt_d = '0;
      end
      PH_RECOVER: begin
        if (req) begin
          ph_d  = PH_ENTERING;
          cnt_d = CW'(1);
        end else if (rec_done) begin
          ph_d  = PH_ACTIVE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + CW'(1);
        end
      end
      default: begin
        ph_d  = PH_ACTIVE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q  <= PH_ACTIVE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign phase     = ph_q;
  assign enter_evt = (ph_d == PH_SLEEP) && (ph_q != PH_SLEEP);
  assign wake_evt  = (ph_d == PH_ACTIVE) && (ph_q == PH_RECOVER);

  AST_SLEEP_VIA_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_ENTERING && !req && ENTER_CYC > 1) |=> (ph_q == PH_ACTIVE)); // R3
  AST_WAKE_TO_RECOVER: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SLEEP && !req) |=> (ph_q == PH_RECOVER)); // R5
  AST_RECOVER_REENTRY: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_RECOVER && req) |=> (ph_q == PH_ENTERING || ENTER_CYC <= 1)); // R9
  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_SLEEP && req) |=> (ph_q == PH_SLEEP)); // R2

endmodule

// File: rtl/slp_cmd_gate.sv
module slp_cmd_gate
  import mem_sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  slp_phase_t phase,
  input  logic       cmd_vld,
  input  logic       cmd_wr,
  output logic       core_vld,
  output logic       core_wr,
  output logic       drv_en,
  output logic       wr_err
);
  logic [1:0] g;
  logic       bad_wr;
  logic       err_q;

  assign g        = gate_cmd(phase, cmd_vld, cmd_wr);
  assign core_vld = g[0];
  assign core_wr  = g[1];
  assign drv_en   = drivers_on(phase);
  assign bad_wr   = (phase == PH_RECOVER) && cmd_vld && cmd_wr;

  always_ff @(posedge clk) begin
    if (rst)         err_q <= 1'b0;
    else if (bad_wr) err_q <= 1'b1;
  end

  assign wr_err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R7
  AST_ERR_ON_BAD_WR: assert property (@(posedge clk) disable iff (rst)
    bad_wr |=> err_q); // R7
  AST_RECOVER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RECOVER) |-> !core_wr); // R6

endmodule

// File: rtl/mem_sleep_ctrl.sv
module mem_sleep_ctrl
  import mem_sleep_pkg::*;
#(
  parameter int unsigned ENTER_CYC = 2,
  parameter int unsigned REC_CYC   = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slp_req_i,
  input  logic       cmd_vld_i,
  input  logic       cmd_wr_i,
  output logic       core_vld_o,
  output logic       core_wr_o,
  output logic       drv_en_o,
  output logic [1:0] state_o,
  output logic       wr_err_o
);
  slp_phase_t phase;
  logic enter_evt, wake_evt;

  slp_phase_fsm #(.ENTER_CYC(ENTER_CYC), .REC_CYC(REC_CYC)) u_fsm (
    .clk(clk), .rst(rst), .req(slp_req_i),
    .phase(phase), .enter_evt(enter_evt), .wake_evt(wake_evt)
  );

  slp_cmd_gate u_gate (
    .clk(clk), .rst(rst), .phase(phase),
    .cmd_vld(cmd_vld_i), .cmd_wr(cmd_wr_i),
    .core_vld(core_vld_o), .core_wr(core_wr_o),
    .drv_en(drv_en_o), .wr_err(wr_err_o)
  );

  assign state_o = phase;

  AST_SLEEP_MASKS: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> (!core_vld_o && !core_wr_o && !drv_en_o)); // R4
  AST_ENTRY_EVENT: assert property (@(posedge clk) disable iff (rst)
    enter_evt |=> (state_o == 2'd2)); // R2
  AST_WAKE_EVENT: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> (state_o == 2'd0)); // R5
  AST_ACTIVE_PASS: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd0) |-> (core_vld_o == cmd_vld_i && drv_en_o)); // R8

endmodule

// File: tb/mem_sleep_ctrl_test.sv
module mem_sleep_ctrl_test;
  localparam int ENTER_CYC = 2;
  localparam int REC_CYC   = 5;

  logic clk = 1'b0;
  logic rst, req, vld, wr;
  logic core_vld, core_wr, drv_en, wr_err;
  logic [1:0] st;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  int m_ph;   // 0 normal,1 entering,2 sleep,3 recover
  int m_high; // consecutive high samples during entry
  int m_rec;  // recovery cycles spent
  bit m_err;

  always #2.5 clk = ~clk;

  mem_sleep_ctrl #(.ENTER_CYC(ENTER_CYC), .REC_CYC(REC_CYC)) uut (
    .clk(clk), .rst(rst), .slp_req_i(req), .cmd_vld_i(vld), .cmd_wr_i(wr),
    .core_vld_o(core_vld), .core_wr_o(core_wr), .drv_en_o(drv_en),
    .state_o(st), .wr_err_o(wr_err)
  );

  function automatic bit x_vld(int ph, bit v, bit w);
    if (ph == 2) return 0;
    if (ph == 3) return v && !w;
    return v;
  endfunction

  function automatic bit x_wr(int ph, bit v, bit w);
    return (ph == 0 || ph == 1) ? (v & w) : 1'b0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string tv;
    tv = (m_ph == 2) ? "R4" : (m_ph == 3) ? "R6" : "R8";
    chk("R2/R3/R5/R9 state", st, m_ph);
    chk({tv, " core_vld"}, core_vld, x_vld(m_ph, vld, wr));
    chk({tv, " core_wr"}, core_wr, x_wr(m_ph, vld, wr));
    chk({tv, " drv_en"}, drv_en, m_ph != 2);
    chk("R7 wr_err", wr_err, m_err);
  endtask

  task automatic model_edge();
    if (rst) begin
      m_ph = 0; m_high = 0; m_rec = 0; m_err = 0;
      return;
    end
    if (m_ph == 3 && vld && wr) m_err = 1;
    case (m_ph)
      0: if (req) begin m_high = 1; m_ph = (m_high >= ENTER_CYC) ? 2 : 1; end
      1: if (!req) m_ph = 0;
         else begin m_high++; if (m_high >= ENTER_CYC) m_ph = 2; end
      2: if (!req) begin m_ph = 3; m_rec = 0; end
      default: if (req) begin m_ph = 1; m_high = 1; end
               else begin m_rec++; if (m_rec >= REC_CYC) m_ph = 0; end
    endcase
  endtask

  // one cycle: drive at negedge, check, then take the edge
  task automatic step(bit r, bit v, bit w);
    @(negedge clk);
    req = r; vld = v; wr = w;
    #1 check_all();
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    bit rq;
    seed = $urandom(32'd20240611);
    rst = 1; req = 0; vld = 0; wr = 0;
    m_ph = 0; m_high = 0; m_rec = 0; m_err = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 0;
    #1;
    // R1 reset state
    chk("R1 state", st, 0);
    chk("R1 wr_err", wr_err, 0);
    chk("R1 drv_en", drv_en, 1);

    // R2 entry takes two edges, R4 commands ignored in sleep
    step(1, 1, 1); step(1, 1, 0); step(1, 1, 1); step(1, 1, 1);
    // R5 wake then full recovery with reads, R6
    step(0, 1, 0);
    for (int i = 0; i < REC_CYC; i++) step(0, 1, 0);
    step(0, 0, 0);
    // R3 abort after one entry edge
    step(1, 0, 0); step(0, 1, 1); step(0, 0, 0);
    // R9 re-request in mid recovery
    step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    // R7 write in recovery then sticky
    step(0, 0, 0); step(0, 1, 1);
    for (int i = 0; i < 8; i++) step(0, 1, 1);
    // reset clears flag (R1)
    @(negedge clk); rst = 1;
    @(posedge clk); model_edge();
    @(negedge clk); rst = 0;
    #1 check_all();

    // random run with slowly changing request
    rq = 0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 7) == 0) rq = ~rq;
      step(rq, $urandom_range(0, 1), $urandom_range(0, 1));
      if (i % 1000 == 999) begin
        @(negedge clk); rst = 1;
        @(posedge clk); model_edge();
        @(negedge clk); rst = 0;
      end
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule